// File: doc/BRIEF.md
# Outbound Windowed Address Translator

This block sits on the outbound path of a bus master and rewrites CPU addresses that fall in a 128 MB windowed region. The region is split into eight 16 MB windows. Each window has its own 32-bit offset register, written through a plain register-write port. For an address inside the region, the block drops the upper address bits and the window-select bits. It then adds the chosen window's offset to the remaining 24-bit position inside the window. Addresses outside the region pass through unchanged.

Each address arrives with a valid strobe. One clock later the block presents the translated address, a hit flag and a matching valid. The path carries valid only, with no ready. The output cannot be stalled, so the consumer must accept every result in the cycle it appears. Traffic arriving from the downstream side does not use this path and is never translated.

Top module: `owx_window_xlat`

## Requirements
- R1: After reset, out_valid and out_hit are 0 and all eight offsets are 0. A windowed access at that point returns only its low 24 bits, zero-extended.
- R2: When in_valid is 1 and in_addr[27] is 0, the access hits. out_addr is the sum of {8'h00, in_addr[23:0]} and the offset of window in_addr[26:24], and out_hit is 1.
- R3: For a hit, in_addr[31:28] has no effect on out_addr.
- R4: When in_valid is 1 and in_addr[27] is 1, out_hit is 0 and out_addr equals in_addr.
- R5: The sum wraps modulo 2^32 and no carry is reported.
- R6: A write with cfg_we=1 loads cfg_data into window cfg_idx only. An address sampled on the same edge still sees the old offset. Addresses sampled on any later edge see the new offset.
- R7: out_valid equals in_valid one cycle earlier. out_hit is 0 whenever out_valid is 0.
- R8: Input 0x100000FF with window 0 offset 0x10000000 gives 0x100000FF. Input 0x120000FF with window 2 offset 0x12000000 gives 0x120000FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Offset register write strobe |
| cfg_idx | input | 3 | Window whose offset is written |
| cfg_data | input | 32 | New offset value |
| in_valid | input | 1 | Input address valid |
| in_addr | input | 32 | CPU address |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | 32 | Translated or passed-through address |
| out_hit | output | 1 | Result came from the windowed region |

## Verification
The hardest case to reach from the ports is a register write and a translation of the same window landing on one clock edge. The read must still return the old offset, and the very next access must return the new one. The stimulus builds this case on purpose. It writes window k and presents an address in window k in the same cycle, then repeats the address in the next cycle. Random traffic also mixes writes with lookups. Offsets near 2^32 are used to force the addition to wrap.

// File: rtl/owx_pkg.sv
package owx_pkg;
  localparam int OWX_ADDR_W   = 32;
  localparam int OWX_NUM_WIN  = 8;
  localparam int OWX_WIN_LOG2 = 24;
endpackage

// File: rtl/owx_win_regs.sv
module owx_win_regs #(
  parameter int ADDR_W  = owx_pkg::OWX_ADDR_W,
  parameter int NUM_WIN = owx_pkg::OWX_NUM_WIN,
  localparam int SEL_W  = $clog2(NUM_WIN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [SEL_W-1:0]               widx,
  input  logic [ADDR_W-1:0]              wdata,
  output logic [NUM_WIN-1:0][ADDR_W-1:0] offs
);
  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             offs[g] <= '0;
      else if (we && widx == SEL_W'(g))       offs[g] <= wdata;
    end
  end
endmodule

// File: rtl/owx_decode.sv
module owx_decode #(
  parameter int NUM_WIN  = owx_pkg::OWX_NUM_WIN,
  parameter int WIN_LOG2 = owx_pkg::OWX_WIN_LOG2,
  localparam int SEL_W   = $clog2(NUM_WIN),
  localparam int REG_BIT = WIN_LOG2 + SEL_W
) (
  input  logic [REG_BIT:0]    addr_low,
  output logic                hit,
  output logic [SEL_W-1:0]    sel,
  output logic [WIN_LOG2-1:0] pos
);
  always_comb begin
    hit = ~addr_low[REG_BIT];
    sel = addr_low[REG_BIT-1:WIN_LOG2];
    pos = addr_low[WIN_LOG2-1:0];
  end
endmodule

// File: rtl/owx_add_stage.sv
module owx_add_stage #(
  parameter int ADDR_W   = owx_pkg::OWX_ADDR_W,
  parameter int NUM_WIN  = owx_pkg::OWX_NUM_WIN,
  parameter int WIN_LOG2 = owx_pkg::OWX_WIN_LOG2,
  localparam int SEL_W   = $clog2(NUM_WIN)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           valid_i,
  input  logic                           hit_i,
  input  logic [SEL_W-1:0]               sel_i,
  input  logic [WIN_LOG2-1:0]            pos_i,
  input  logic [ADDR_W-1:0]              pass_i,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0] offs_i,
  output logic                           valid_o,
  output logic                           hit_o,
  output logic [ADDR_W-1:0]              addr_o
);
  logic [ADDR_W-1:0] win_off, sum, nxt;

  always_comb begin
    win_off = offs_i[sel_i];
    sum     = ADDR_W'(pos_i) + win_off;
    nxt     = hit_i ? sum : pass_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      hit_o   <= 1'b0;
      addr_o  <= '0;
    end else begin
      valid_o <= valid_i;
      hit_o   <= valid_i & hit_i;
      if (valid_i) addr_o <= nxt;
    end
  end
endmodule

// File: rtl/owx_window_xlat.sv
module owx_window_xlat #(
  parameter int ADDR_W   = owx_pkg::OWX_ADDR_W,
  parameter int NUM_WIN  = owx_pkg::OWX_NUM_WIN,
  parameter int WIN_LOG2 = owx_pkg::OWX_WIN_LOG2,
  localparam int SEL_W   = $clog2(NUM_WIN),
  localparam int REG_BIT = WIN_LOG2 + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_idx,
  input  logic [ADDR_W-1:0] cfg_data,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_hit
);
  logic [NUM_WIN-1:0][ADDR_W-1:0] offs;
  logic                           dec_hit;
  logic [SEL_W-1:0]               dec_sel;
  logic [WIN_LOG2-1:0]            dec_pos;

  owx_win_regs #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .widx(cfg_idx),
    .wdata(cfg_data), .offs(offs)
  );

  owx_decode #(.NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2)) dec_i (
    .addr_low(in_addr[REG_BIT:0]), .hit(dec_hit), .sel(dec_sel), .pos(dec_pos)
  );

  owx_add_stage #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .WIN_LOG2(WIN_LOG2)) add_i (
    .clk(clk), .rst_n(rst_n), .valid_i(in_valid), .hit_i(dec_hit),
    .sel_i(dec_sel), .pos_i(dec_pos), .pass_i(in_addr), .offs_i(offs),
    .valid_o(out_valid), .hit_o(out_hit), .addr_o(out_addr)
  );
endmodule

// File: rtl/owx_window_xlat_chk.sv
module owx_window_xlat_chk #(
  parameter int ADDR_W  = 32,
  parameter int REG_BIT = 27
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              out_hit
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R7
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R7
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) out_hit |-> out_valid); // R7
  AST_REGION_HIT: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && !in_addr[REG_BIT]) |=> out_hit); // R2
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && in_addr[REG_BIT]) |=> (!out_hit && out_addr == $past(in_addr))); // R4
endmodule

bind owx_window_xlat owx_window_xlat_chk #(.ADDR_W(ADDR_W), .REG_BIT(REG_BIT)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
  .out_valid(out_valid), .out_addr(out_addr), .out_hit(out_hit)
);

// File: tb/owx_window_xlat_tb_top.sv
module owx_window_xlat_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic        in_valid = 1'b0;
  logic [31:0] in_addr = '0;
  logic        out_valid, out_hit;
  logic [31:0] out_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  owx_window_xlat dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid),
    .out_addr(out_addr), .out_hit(out_hit)
  );

  function automatic logic [31:0] exp_addr(input logic [31:0] a);
    if (a[27]) return a;
    return {8'h00, a[23:0]} + model[a[26:24]];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle of stimulus; optionally write and/or translate
  task automatic step(input bit wr, input logic [2:0] wi, input logic [31:0] wd,
                      input bit rd, input logic [31:0] a, input string req);
    logic [31:0] e;
    @(negedge clk);
    cfg_we = wr; cfg_idx = wi; cfg_data = wd;
    in_valid = rd; in_addr = a;
    e = exp_addr(a);  // old offset applies on the write edge
    @(posedge clk); #1;
    if (wr) model[wi] = wd;
    chk({req, " valid"}, {31'd0, out_valid}, {31'd0, rd});
    if (rd) begin
      chk({req, " hit"}, {31'd0, out_hit}, {31'd0, ~a[27]});
      chk({req, " addr"}, out_addr, e);
    end else begin
      chk({req, " idle hit"}, {31'd0, out_hit}, 32'd0);
    end
    cfg_we = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0123));
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset valid", {31'd0, out_valid}, 32'd0);
    chk("R1 reset hit", {31'd0, out_hit}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 32'h0512_3456, "R1 zero offset");
    step(0, 0, 0, 1, 32'h0000_0000, "R1 zero offset");
    // R8 worked examples
    step(1, 3'd0, 32'h1000_0000, 0, 0, "R6 write");
    step(1, 3'd2, 32'h1200_0000, 0, 0, "R6 write");
    step(0, 0, 0, 1, 32'h1000_00FF, "R8 win0");
    chk("R8 win0 value", out_addr, 32'h1000_00FF);
    step(0, 0, 0, 1, 32'h1200_00FF, "R8 win2");
    chk("R8 win2 value", out_addr, 32'h1200_00FF);
    // R3 upper nibble ignored
    step(0, 0, 0, 1, 32'hF200_00FF, "R3 upper");
    chk("R3 upper value", out_addr, 32'h1200_00FF);
    // R4 passthrough
    step(0, 0, 0, 1, 32'h0800_0001, "R4 miss");
    step(0, 0, 0, 1, 32'hFFFF_FFFF, "R4 miss");
    // R5 wrap
    step(1, 3'd5, 32'hFFFF_FF00, 0, 0, "R6 write");
    step(0, 0, 0, 1, 32'h0500_0180, "R5 wrap");
    chk("R5 wrap value", out_addr, 32'h0000_0080);
    // R6 same-edge write and read, then next cycle
    step(1, 3'd4, 32'h2222_0000, 1, 32'h0400_0010, "R6 same edge");
    chk("R6 same edge old", out_addr, 32'h0000_0010);
    step(0, 0, 0, 1, 32'h0400_0010, "R6 next");
    chk("R6 next new", out_addr, 32'h2222_0010);
    step(0, 0, 0, 1, 32'h0200_0010, "R6 other untouched");
    // R7 idle cycle
    step(0, 0, 0, 0, 0, "R7 idle");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom_range(0, 9);
      logic [31:0] ra = $urandom();
      logic [31:0] rd = $urandom();
      if (kind < 2) step(1, rd[2:0], $urandom(), 0, 0, "R6 rand write");
      else if (kind < 3) step(1, rd[2:0], $urandom(), 1, ra, "R6 rand same edge");
      else if (kind < 4) step(0, 0, 0, 0, 0, "R7 rand idle");
      else if (kind < 7) step(0, 0, 0, 1, {ra[31:28], 1'b0, ra[26:0]}, "R2 rand hit");
      else step(0, 0, 0, 1, ra, "R4 rand any");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule